// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home node for a region of block-addressed shared memory that N caches use over point-to-point channels. Each block has one data word and a directory entry. The entry holds a dirty flag and a presence vector with one bit for each cache. Caches send two request kinds: a read miss and a request for write permission. A write miss is sent as a read miss followed by a write-permission request. Because the home node knows exactly which caches hold a block, it sends invalidations only to those caches. It does not broadcast.

If the entry is clean, a read miss is answered from memory. If the entry is dirty, the read is redirected to the single owning cache. That cache returns the block, which is written back to memory before it is forwarded to the requester. A write-permission request causes the controller to invalidate every other holder and count their acknowledgements. Only then does it mark the entry dirty with the requester as the sole holder and send a grant. A cache that receives data holds it read-only, and it sets write-enable only when the grant arrives.

Incoming requests go into a FIFO. The controller handles one transaction at a time and takes requests in the order they arrived.

Top module: `dirmap_home`

## Requirements
- R1: After reset, `rsp_valid` and `snp_valid` are low and `req_ready` is high. Every entry is clean, with no holders and data zero.
- R2: A read miss (`req_kind`=0) on a clean entry produces one response with `rsp_kind`=0 (data) carrying the memory word. It sends no snoop, and it adds the requester to the presence vector.
- R3: A read miss on a dirty entry sends exactly one snoop with `snp_kind`=0 (fetch) to the owner. The word the owner returns is written to memory and sent to the requester as data. The entry becomes clean, and both caches remain holders.
- R4: A write-permission request (`req_kind`=1) sends one snoop with `snp_kind`=1 (invalidate) to each other cache in the presence vector. No snoop goes to the requester or to any cache that does not hold the block.
- R5: The grant (`rsp_kind`=1) is issued only in a cycle after the last expected acknowledgement has been received. With no other holders, the grant is issued with no snoop at all.
- R6: After a grant, the entry is dirty and the requester is its only holder, so a later read is fetched from that cache. When an invalidated cache is the dirty owner, the word in its acknowledgement (`cack_has_data`=1) updates memory.
- R7: Requests are serviced in arrival order. `req_ready` is low while the queue holds QDEPTH requests.
- R8: Each request produces exactly one response, and responses are never issued in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can accept a request |
| req_src | input | $clog2(NCACHE) | Requesting cache |
| req_kind | input | 1 | 0 read miss, 1 write permission |
| req_blk | input | $clog2(BLOCKS) | Block index |
| snp_valid | output | 1 | Snoop to one cache this cycle |
| snp_kind | output | 1 | 0 fetch-and-downgrade, 1 invalidate |
| snp_dst | output | $clog2(NCACHE) | Snooped cache |
| snp_blk | output | $clog2(BLOCKS) | Snooped block |
| cack_valid | input | 1 | Acknowledgement from a snooped cache |
| cack_has_data | input | 1 | Acknowledgement carries a dirty word |
| cack_data | input | DW | Returned word |
| rsp_valid | output | 1 | Response to requester |
| rsp_kind | output | 1 | 0 data, 1 write grant |
| rsp_dst | output | $clog2(NCACHE) | Destination cache |
| rsp_data | output | DW | Block word for data responses |

## Verification
A single block is driven through a fixed sequence that exercises each directory transition. The sequence starts with three readers. One of them is upgraded while two sharers exist, and a fourth cache then reads the block from the dirty owner. Two writes follow: an upgrade by a cache that already owns the block, which must produce no snoop, and a write by a cache without a copy, which must pull the owner's word back through its invalidation acknowledgement. The snoop mask recorded for each transaction is compared with the expected one. This comparison separates correct targeted invalidation from a broadcast, from a missed sharer and from a snoop sent to the requester. A second phase sets a long acknowledgement latency and queues reads behind a pending upgrade. It shows whether the grant waits for the acknowledgements, whether back-pressure appears at the queue depth, and whether replies come out in arrival order.

// File: rtl/dirmap_pkg.sv
// dirmap_pkg: encodings shared by the directory home controller and its parts.
// Assumes single-bit request, snoop and response kind fields.
package dirmap_pkg;
    localparam logic KIND_READ  = 1'b0;
    localparam logic KIND_WPERM = 1'b1;
    localparam logic SNP_FETCH  = 1'b0;
    localparam logic SNP_INVAL  = 1'b1;
    localparam logic RSP_DATA   = 1'b0;
    localparam logic RSP_GRANT  = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_INVAL,
        ST_FETCH
    } home_state_e;
endpackage

// File: rtl/dirmap_req_fifo.sv
// dirmap_req_fifo: arrival-order request queue in front of the home FSM.
// Assumes push is never asserted when full and pop never when empty.
module dirmap_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] fill;

    assign head  = slots[rp];
    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));

    // Pointer and occupancy update with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            fill <= fill + CW'(push) - CW'(pop);
        end
    end

    // Slot storage write.
    always_ff @(posedge clk) begin
        if (push) slots[wp] <= push_data;
    end

    // R7
    fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7
    fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dirmap_entry_store.sv
// dirmap_entry_store: per-block data word plus dirty flag and presence vector.
// Assumes one block is addressed at a time. Reads are combinational and writes
// take effect at the clock edge. Reset clears all data and directory state.
module dirmap_entry_store #(
    parameter int BLOCKS = 16,
    parameter int NCACHE = 4,
    parameter int DW     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BLOCKS)-1:0] blk,
    output logic                      ent_dirty,
    output logic [NCACHE-1:0]         ent_pres,
    output logic [DW-1:0]             ent_data,
    input  logic                      dir_we,
    input  logic                      dir_wdirty,
    input  logic [NCACHE-1:0]         dir_wpres,
    input  logic                      mem_we,
    input  logic [DW-1:0]             mem_wdata
);
    logic              dirty_q [BLOCKS];
    logic [NCACHE-1:0] pres_q  [BLOCKS];
    logic [DW-1:0]     data_q  [BLOCKS];

    assign ent_dirty = dirty_q[blk];
    assign ent_pres  = pres_q[blk];
    assign ent_data  = data_q[blk];

    // Directory and data array update; reset zeroes every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BLOCKS; i++) begin
                dirty_q[i] <= 1'b0;
                pres_q[i]  <= '0;
                data_q[i]  <= '0;
            end
        end else begin
            if (dir_we) begin
                dirty_q[blk] <= dir_wdirty;
                pres_q[blk]  <= dir_wpres;
            end
            if (mem_we) data_q[blk] <= mem_wdata;
        end
    end

    // R6
    dirty_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_we && dir_wdirty) |-> ($countones(dir_wpres) == 1));
endmodule

// File: rtl/dirmap_home.sv
// dirmap_home: full-map directory home node. It serves read misses and
// write-permission requests one at a time, in arrival order. Assumes each snooped
// cache returns exactly one acknowledgement per snoop on cack_*, one per cycle,
// and that the data channel to requesters is always accepted.
module dirmap_home
    import dirmap_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int BLOCKS = 16,
    parameter int DW     = 32,
    parameter int QDEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [$clog2(NCACHE)-1:0] req_src,
    input  logic                      req_kind,
    input  logic [$clog2(BLOCKS)-1:0] req_blk,
    output logic                      snp_valid,
    output logic                      snp_kind,
    output logic [$clog2(NCACHE)-1:0] snp_dst,
    output logic [$clog2(BLOCKS)-1:0] snp_blk,
    input  logic                      cack_valid,
    input  logic                      cack_has_data,
    input  logic [DW-1:0]             cack_data,
    output logic                      rsp_valid,
    output logic                      rsp_kind,
    output logic [$clog2(NCACHE)-1:0] rsp_dst,
    output logic [DW-1:0]             rsp_data
);
    localparam int IDW = $clog2(NCACHE);
    localparam int BW  = $clog2(BLOCKS);
    localparam int CW  = IDW + 1;
    localparam int QW  = IDW + 1 + BW;

    // Lowest-numbered cache set in a vector.
    function automatic logic [IDW-1:0] first_one(input logic [NCACHE-1:0] v);
        logic [IDW-1:0] r;
        r = '0;
        for (int i = NCACHE - 1; i >= 0; i--) if (v[i]) r = IDW'(i);
        return r;
    endfunction

    // Number of caches set in a vector.
    function automatic logic [CW-1:0] count_set(input logic [NCACHE-1:0] v);
        logic [CW-1:0] c;
        c = '0;
        for (int i = 0; i < NCACHE; i++) c = c + CW'(v[i]);
        return c;
    endfunction

    home_state_e       state;
    logic [IDW-1:0]    cur_src;
    logic              cur_kind;
    logic [BW-1:0]     cur_blk;
    logic [NCACHE-1:0] pend;
    logic [CW-1:0]     need, got, got_n;

    logic          q_empty, q_full, q_pop;
    logic [QW-1:0] q_head;

    logic              ent_dirty;
    logic [NCACHE-1:0] ent_pres;
    logic [DW-1:0]     ent_data;
    logic              dir_we, dir_wdirty, mem_we;
    logic [NCACHE-1:0] dir_wpres, req_bit, others;
    logic              inval_done;

    assign req_ready  = !q_full;
    assign q_pop      = (state == ST_IDLE) && !q_empty;
    assign req_bit    = NCACHE'(1) << cur_src;
    assign others     = ent_pres & ~req_bit;
    assign got_n      = got + CW'(cack_valid);
    assign inval_done = (pend == '0) && (got_n == need);
    assign snp_blk    = cur_blk;

    dirmap_req_fifo #(.W(QW), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_valid && req_ready),
        .push_data ({req_src, req_kind, req_blk}),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    dirmap_entry_store #(.BLOCKS(BLOCKS), .NCACHE(NCACHE), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk        (cur_blk),
        .ent_dirty  (ent_dirty),
        .ent_pres   (ent_pres),
        .ent_data   (ent_data),
        .dir_we     (dir_we),
        .dir_wdirty (dir_wdirty),
        .dir_wpres  (dir_wpres),
        .mem_we     (mem_we),
        .mem_wdata  (cack_data)
    );

    // Directory and memory write decisions for the current state.
    always_comb begin
        dir_we     = 1'b0;
        dir_wdirty = 1'b0;
        dir_wpres  = ent_pres;
        mem_we     = 1'b0;
        case (state)
            ST_EXEC: begin
                if (cur_kind == KIND_READ && !ent_dirty) begin
                    dir_we    = 1'b1;
                    dir_wpres = ent_pres | req_bit;
                end else if (cur_kind == KIND_WPERM && others == '0) begin
                    dir_we     = 1'b1;
                    dir_wdirty = 1'b1;
                    dir_wpres  = req_bit;
                end
            end
            ST_INVAL: begin
                mem_we = cack_valid && cack_has_data;
                if (inval_done) begin
                    dir_we     = 1'b1;
                    dir_wdirty = 1'b1;
                    dir_wpres  = req_bit;
                end
            end
            ST_FETCH: begin
                mem_we    = cack_valid;
                dir_we    = cack_valid;
                dir_wpres = ent_pres | req_bit;
            end
            default: ;
        endcase
    end

    // Transaction sequencing, snoop issue and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_src   <= '0;
            cur_kind  <= 1'b0;
            cur_blk   <= '0;
            pend      <= '0;
            need      <= '0;
            got       <= '0;
            snp_valid <= 1'b0;
            snp_kind  <= 1'b0;
            snp_dst   <= '0;
            rsp_valid <= 1'b0;
            rsp_kind  <= 1'b0;
            rsp_dst   <= '0;
            rsp_data  <= '0;
        end else begin
            snp_valid <= 1'b0;
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (q_pop) begin
                        {cur_src, cur_kind, cur_blk} <= q_head;
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (cur_kind == KIND_READ) begin
                        if (!ent_dirty) begin
                            rsp_valid <= 1'b1;
                            rsp_kind  <= RSP_DATA;
                            rsp_dst   <= cur_src;
                            rsp_data  <= ent_data;
                            state     <= ST_IDLE;
                        end else begin
                            snp_valid <= 1'b1;
                            snp_kind  <= SNP_FETCH;
                            snp_dst   <= first_one(ent_pres);
                            state     <= ST_FETCH;
                        end
                    end else if (others == '0) begin
                        rsp_valid <= 1'b1;
                        rsp_kind  <= RSP_GRANT;
                        rsp_dst   <= cur_src;
                        state     <= ST_IDLE;
                    end else begin
                        pend  <= others;
                        need  <= count_set(others);
                        got   <= '0;
                        state <= ST_INVAL;
                    end
                end
                ST_INVAL: begin
                    got <= got_n;
                    if (pend != '0) begin
                        snp_valid <= 1'b1;
                        snp_kind  <= SNP_INVAL;
                        snp_dst   <= first_one(pend);
                        pend      <= pend & ~(NCACHE'(1) << first_one(pend));
                    end
                    if (inval_done) begin
                        rsp_valid <= 1'b1;
                        rsp_kind  <= RSP_GRANT;
                        rsp_dst   <= cur_src;
                        state     <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    if (cack_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_kind  <= RSP_DATA;
                        rsp_dst   <= cur_src;
                        rsp_data  <= cack_data;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    snoop_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (snp_dst != cur_src));
    // R8
    rsp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R3
    fetch_one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_kind == SNP_FETCH) |-> (state == ST_FETCH));
endmodule

// File: tb/tb_dirmap_home.sv
module tb_dirmap_home;
    localparam int N  = 4;
    localparam int NB = 16;
    localparam int DW = 32;
    localparam int QD = 4;

    typedef struct packed {
        logic [1:0]  src;
        logic        kind;
        logic [3:0]  blk;
        logic [31:0] wval;
        logic        ekind;
        logic [31:0] edata;
        logic [3:0]  emask;
    } vec_t;

    // src, kind, blk, value written after grant, expected rsp kind/data, snoop mask
    localparam vec_t VECS [13] = '{
        '{2'd0, 1'b0, 4'd1, 32'h0,  1'b0, 32'h0,  4'b0000},
        '{2'd1, 1'b0, 4'd1, 32'h0,  1'b0, 32'h0,  4'b0000},
        '{2'd2, 1'b0, 4'd1, 32'h0,  1'b0, 32'h0,  4'b0000},
        '{2'd1, 1'b1, 4'd1, 32'hA1, 1'b1, 32'h0,  4'b0101},
        '{2'd3, 1'b0, 4'd1, 32'h0,  1'b0, 32'hA1, 4'b0010},
        '{2'd0, 1'b0, 4'd1, 32'h0,  1'b0, 32'hA1, 4'b0000},
        '{2'd3, 1'b1, 4'd1, 32'hB2, 1'b1, 32'h0,  4'b0011},
        '{2'd3, 1'b1, 4'd1, 32'hC3, 1'b1, 32'h0,  4'b0000},
        '{2'd2, 1'b1, 4'd1, 32'hD4, 1'b1, 32'h0,  4'b1000},
        '{2'd0, 1'b0, 4'd1, 32'h0,  1'b0, 32'hD4, 4'b0100},
        '{2'd0, 1'b0, 4'd5, 32'h0,  1'b0, 32'h0,  4'b0000},
        '{2'd0, 1'b1, 4'd5, 32'hE5, 1'b1, 32'h0,  4'b0000},
        '{2'd1, 1'b0, 4'd5, 32'h0,  1'b0, 32'hE5, 4'b0001}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_kind = 1'b0;
    logic [1:0] req_src = '0;
    logic [3:0] req_blk = '0;
    logic req_ready, snp_valid, snp_kind, rsp_valid, rsp_kind;
    logic [1:0] snp_dst, rsp_dst;
    logic [3:0] snp_blk;
    logic cack_valid = 1'b0, cack_has_data = 1'b0;
    logic [DW-1:0] cack_data = '0;
    logic [DW-1:0] rsp_data;

    dirmap_home #(.NCACHE(N), .BLOCKS(NB), .DW(DW), .QDEPTH(QD)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_kind(req_kind), .req_blk(req_blk),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_dst(snp_dst), .snp_blk(snp_blk),
        .cack_valid(cack_valid), .cack_has_data(cack_has_data), .cack_data(cack_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst), .rsp_data(rsp_data)
    );

    always #5 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    int lag = 1;
    logic [DW-1:0] cval [N][NB];
    int owner [NB];
    int rsp_n = 0, snp_n = 0;
    logic [1:0] rsp_log_dst [64];
    logic rsp_log_kind [64];
    logic [DW-1:0] rsp_log_data [64];
    logic [1:0] snp_log_dst [64];
    int last_ack_cyc = 0, grant_cyc = 0;
    logic pl_v [16];
    logic pl_h [16];
    logic [DW-1:0] pl_d [16];

    always @(posedge clk) cyc <= cyc + 1;

    // Cache models: log traffic and return acknowledgements 'lag' cycles later.
    always @(negedge clk) begin
        cack_valid    = pl_v[0];
        cack_has_data = pl_h[0];
        cack_data     = pl_d[0];
        if (pl_v[0]) last_ack_cyc = cyc;
        for (int i = 0; i < 15; i++) begin
            pl_v[i] = pl_v[i+1]; pl_h[i] = pl_h[i+1]; pl_d[i] = pl_d[i+1];
        end
        pl_v[15] = 1'b0;
        if (rsp_valid) begin
            rsp_log_dst[rsp_n % 64]  = rsp_dst;
            rsp_log_kind[rsp_n % 64] = rsp_kind;
            rsp_log_data[rsp_n % 64] = rsp_data;
            if (rsp_kind) grant_cyc = cyc;
            rsp_n++;
        end
        if (snp_valid) begin
            snp_log_dst[snp_n % 64] = snp_dst;
            snp_n++;
            pl_v[lag-1] = 1'b1;
            pl_h[lag-1] = (snp_kind == 1'b0) || (owner[snp_blk] == int'(snp_dst));
            pl_d[lag-1] = cval[snp_dst][snp_blk];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] s, input logic k, input logic [3:0] b);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_src = s; req_kind = k; req_blk = b;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Update cache models with the response a request received.
    task automatic absorb(input int idx, input logic [1:0] s, input logic [3:0] b, input logic [31:0] wv);
        if (rsp_log_kind[idx % 64]) begin
            cval[s][b] = wv;
            owner[b]   = int'(s);
        end else begin
            cval[s][b] = rsp_log_data[idx % 64];
            owner[b]   = -1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) for (int b = 0; b < NB; b++) cval[c][b] = '0;
        for (int b = 0; b < NB; b++) owner[b] = -1;
        for (int i = 0; i < 16; i++) begin pl_v[i] = 1'b0; pl_h[i] = 1'b0; pl_d[i] = '0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check(rsp_valid == 1'b0, "R1", rsp_valid, 0);
        check(snp_valid == 1'b0, "R1", snp_valid, 0);
        check(req_ready == 1'b1, "R1", req_ready, 1);

        // Table walk: R2 clean reads, R3 owner fetch, R4 invalidation, R5 grant, R6 owner handling
        for (int i = 0; i < 13; i++) begin
            automatic vec_t v = VECS[i];
            automatic int r0 = rsp_n, s0 = snp_n;
            automatic logic [3:0] m = '0;
            automatic string tag;
            if (i == 8 || i == 9) tag = "R6";
            else if (v.kind) tag = (v.emask != 0) ? "R4" : "R5";
            else tag = (v.emask != 0) ? "R3" : "R2";
            push(v.src, v.kind, v.blk);
            while (rsp_n == r0) @(posedge clk);
            repeat (2) @(posedge clk);
            for (int k = s0; k < snp_n; k++) m[snp_log_dst[k % 64]] = 1'b1;
            check(rsp_log_kind[r0 % 64] == v.ekind, tag, rsp_log_kind[r0 % 64], v.ekind);
            check(rsp_log_dst[r0 % 64] == v.src, tag, rsp_log_dst[r0 % 64], v.src);
            if (!v.ekind) check(rsp_log_data[r0 % 64] == v.edata, tag, rsp_log_data[r0 % 64], v.edata);
            check(m == v.emask && (snp_n - s0) == $countones(v.emask), tag, m, v.emask);
            // R8 exactly one response per request
            check(rsp_n == r0 + 1, "R8", rsp_n - r0, 1);
            absorb(r0, v.src, v.blk, v.wval);
        end

        // R5/R7: slow acknowledgements, queue fill and service order
        begin
            automatic int r0;
            lag = 10;
            r0 = rsp_n;
            push(2'd0, 1'b0, 4'd9);
            while (rsp_n == r0) @(posedge clk);
            absorb(r0, 2'd0, 4'd9, 32'h0);
            r0 = rsp_n;
            push(2'd1, 1'b1, 4'd9);
            push(2'd2, 1'b0, 4'd10);
            push(2'd3, 1'b0, 4'd11);
            push(2'd2, 1'b0, 4'd12);
            push(2'd3, 1'b0, 4'd13);
            check(req_ready == 1'b0, "R7", req_ready, 0);
            while (rsp_n < r0 + 5) @(posedge clk);
            repeat (2) @(posedge clk);
            check(rsp_log_kind[r0 % 64] == 1'b1 && rsp_log_dst[r0 % 64] == 2'd1, "R7",
                  {rsp_log_kind[r0 % 64], rsp_log_dst[r0 % 64]}, 3'b101);
            check(grant_cyc > last_ack_cyc || rsp_log_kind[(r0+1) % 64] == 1'b0 && grant_cyc > last_ack_cyc,
                  "R5", grant_cyc, last_ack_cyc + 1);
            check(rsp_log_dst[(r0+1) % 64] == 2'd2 && rsp_log_dst[(r0+2) % 64] == 2'd3 &&
                  rsp_log_dst[(r0+3) % 64] == 2'd2 && rsp_log_dst[(r0+4) % 64] == 2'd3, "R7",
                  {rsp_log_dst[(r0+1) % 64], rsp_log_dst[(r0+2) % 64], rsp_log_dst[(r0+3) % 64], rsp_log_dst[(r0+4) % 64]},
                  8'b10_11_10_11);
            check(req_ready == 1'b1, "R7", req_ready, 1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule